// File: doc/BRIEF.md
# Quiet motor startup sequencer

This block walks a three-phase fan motor from standstill to closed-loop speed control. It produces the drive demand (a 9-bit count by default), a frequency command for the open-loop modulator and a flag that tells the rest of the drive when position sensing is in charge. While the start request is held, it moves through five stages. It first raises the drive amplitude from zero to an open-loop level over a fixed soft-start window, at a fixed low frequency. It then raises the electrical frequency at a rate picked by a 4-bit parameter code. Next it drops the demand to about half and hands over to position sensing. It holds that level briefly and finally walks the demand toward the externally commanded value, at a pace that depends on whether the demand is in the lowest quarter of full scale.

All timing is counted in ticks of an external 1 ms timebase strobe. The parameter code and the level-select bit are sampled once, on the first clock after reset, and are then fixed until the next reset. Voltage-derived levels arrive as precomputed demand counts through parameters. Withdrawing the start request returns the block to idle at once.

Top module: `quiet_start_seq`

## Requirements
- R1: After reset, and on the clock after any cycle in which `start_req` is low, `demand` is 0, `freq_cmd` is 0 and `closed_loop` is 0.
- R2: `param_code` and `drive_sel` are captured on the first rising clock edge after reset release; later changes to them have no effect until the next reset.
- R3: The open-loop level is `LVL_STD_HI` (`drive_sel`=1) or `LVL_STD_LO` (`drive_sel`=0) for codes 0 to 7, and `LVL_EXT_HI` or `LVL_EXT_LO` for codes 8 to 15.
- R4: On the clock after `start_req` is seen high in idle, `freq_cmd` becomes `START_FREQ` and `demand` is 0; after the k-th tick (k = 1..`SOFT_TICKS`), `demand` equals floor(level*k/`SOFT_TICKS`), and `freq_cmd` stays at `START_FREQ`.
- R5: During the next `ACCEL_TICKS` ticks, `freq_cmd` (unit 0.1 mHz) rises on each tick by the code's increment: codes 0..7 give 31, 51, 70, 90, 109, 148, 188, 266, and codes 8..15 give 266.
- R6: `freq_cmd` never exceeds `FMAX_STD` for codes 0..7 or `FMAX_EXT` for codes 8..15; a step that would pass the limit lands on it.
- R7: On the last acceleration tick, `demand` becomes floor(level*`HANDOVER_PCT`/100) and `closed_loop` rises; `demand` and `freq_cmd` then stay unchanged for `HOLD_TICKS` ticks.
- R8: After the hold, a pacing credit starts at 0 and gains 2 on each tick while `demand` differs from `target_dmd`. When the credit reaches the threshold, `demand` moves one count toward the target and the threshold is subtracted from the credit. The threshold is `SLOW_HALF` (30) while `demand` < 2^(DW-2), and `FAST_HALF` (15) otherwise. The credit is cleared while `demand` equals the target.
- R9: The ramp stops exactly at `target_dmd` and also runs downward when the target is below the demand.
- R10: Dropping `start_req` in any stage returns the block to idle on the next clock; a new request restarts from the soft start.
- R11: While `start_req` is high, `demand` changes only on clocks where `tick_1ms` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-clock timebase strobe, nominally every 1 ms |
| start_req | input | 1 | Run request; low forces idle |
| param_code | input | 4 | Startup parameter code, captured once after reset |
| drive_sel | input | 1 | Open-loop level select (1 = higher level), captured once |
| target_dmd | input | DW | Commanded final demand |
| demand | output | DW | Drive demand count |
| freq_cmd | output | FW | Open-loop frequency command, unit 0.1 mHz |
| closed_loop | output | 1 | High while position sensing governs the drive |

## Verification
The bench builds the block with `SOFT_TICKS`=10, `ACCEL_TICKS`=8, `HOLD_TICKS`=4, `FMAX_STD`=10000 and `FMAX_EXT`=20000, and keeps the default levels and pacing. With these short windows, all sixteen codes and both select values can each be swept from a fresh reset through every stage, with every tick compared against arithmetic expectations. The low standard frequency limit makes code 7 hit the clamp while code 6 stays below it. Further runs take the demand up across the quarter-scale pace change and down across it to a settled target, and cut the request off during the soft start, during acceleration and during the final ramp.

// File: rtl/qs_pkg.sv
`timescale 1ns/1ps
package qs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SOFT  = 3'd1,
      ST_ACCEL = 3'd2,
      ST_HOLD  = 3'd3,
      ST_TRACK = 3'd4
   } qs_state_e;

   localparam int INC_W = 9;

   // frequency increment per tick, unit 0.1 mHz per 1 ms tick (= 0.1 Hz/s)
   function automatic logic [INC_W-1:0] accel_inc(input logic [3:0] code);
      logic [INC_W-1:0] r;
      case (code)
         4'd0:    r = 9'd31;
         4'd1:    r = 9'd51;
         4'd2:    r = 9'd70;
         4'd3:    r = 9'd90;
         4'd4:    r = 9'd109;
         4'd5:    r = 9'd148;
         4'd6:    r = 9'd188;
         default: r = 9'd266;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/su_cfg_latch.sv
`timescale 1ns/1ps
module su_cfg_latch #(
   parameter int DW           = 9,
   parameter int FW           = 24,
   parameter int LVL_STD_HI   = 256,
   parameter int LVL_STD_LO   = 128,
   parameter int LVL_EXT_HI   = 85,
   parameter int LVL_EXT_LO   = 43,
   parameter int HANDOVER_PCT = 51,
   parameter int FMAX_STD     = 5000000,
   parameter int FMAX_EXT     = 10000000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [3:0]               code_in,
   input  logic                     sel_in,
   output logic                     cfg_ok,
   output logic [DW-1:0]            lvl,
   output logic [DW-1:0]            ho_lvl,
   output logic [qs_pkg::INC_W-1:0] inc,
   output logic [FW-1:0]            fmax
);
   localparam int HW = DW + 8;

   logic [3:0]    code_q;
   logic          sel_q;
   logic          ext;
   logic [HW-1:0] hprod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_ok <= 1'b0;
         code_q <= '0;
         sel_q  <= 1'b0;
      end else if (!cfg_ok) begin
         cfg_ok <= 1'b1;
         code_q <= code_in;
         sel_q  <= sel_in;
      end
   end

   always_comb begin
      ext = code_q[3];
      if (ext) lvl = sel_q ? DW'(LVL_EXT_HI) : DW'(LVL_EXT_LO);
      else     lvl = sel_q ? DW'(LVL_STD_HI) : DW'(LVL_STD_LO);
      hprod  = HW'(lvl) * HW'(HANDOVER_PCT);
      ho_lvl = DW'(hprod / HW'(100));
      inc    = qs_pkg::accel_inc(code_q);
      fmax   = ext ? FW'(FMAX_EXT) : FW'(FMAX_STD);
   end
endmodule

// File: rtl/su_soft_shape.sv
`timescale 1ns/1ps
module su_soft_shape #(
   parameter int DW         = 9,
   parameter int CW         = 11,
   parameter int SOFT_TICKS = 1230
) (
   input  logic [DW-1:0] lvl,
   input  logic [CW-1:0] k,
   output logic [DW-1:0] amp
);
   localparam int PW = DW + CW;

   logic [PW-1:0] prod;
   assign prod = PW'(lvl) * PW'(k);

   generate
      if ((SOFT_TICKS & (SOFT_TICKS - 1)) == 0) begin : g_shift
         localparam int SH = $clog2(SOFT_TICKS);
         assign amp = DW'(prod >> SH);
      end else begin : g_div
         assign amp = DW'(prod / PW'(SOFT_TICKS));
      end
   endgenerate
endmodule

// File: rtl/su_freq_step.sv
`timescale 1ns/1ps
module su_freq_step #(
   parameter int FW = 24
) (
   input  logic [FW-1:0]            freq,
   input  logic [qs_pkg::INC_W-1:0] inc,
   input  logic [FW-1:0]            fmax,
   output logic [FW-1:0]            freq_nx
);
   logic [FW:0] sum;

   always_comb begin
      sum = {1'b0, freq} + (FW+1)'(inc);
      if (sum > {1'b0, fmax}) freq_nx = fmax;
      else                    freq_nx = sum[FW-1:0];
   end
endmodule

// File: rtl/su_dmd_pacer.sv
`timescale 1ns/1ps
module su_dmd_pacer #(
   parameter int DW        = 9,
   parameter int SLOW_HALF = 30,
   parameter int FAST_HALF = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [DW-1:0] cur,
   input  logic [DW-1:0] target,
   output logic          step_up,
   output logic          step_dn
);
   localparam int QTR = 2 ** (DW - 2);
   localparam int CRW = $clog2(SLOW_HALF + 3);

   logic [CRW-1:0] credit;
   logic [CRW-1:0] sum;
   logic [CRW-1:0] thr;
   logic           differs;
   logic           fire;

   always_comb begin
      differs = (cur != target);
      sum     = credit + CRW'(2);
      thr     = (cur < DW'(QTR)) ? CRW'(SLOW_HALF) : CRW'(FAST_HALF);
      fire    = run && tick && differs && (sum >= thr);
      step_up = fire && (target > cur);
      step_dn = fire && (target < cur);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         credit <= '0;
      end else if (tick) begin
         if (!differs)        credit <= '0;
         else if (sum >= thr) credit <= sum - thr;
         else                 credit <= sum;
      end
   end
endmodule

// File: rtl/quiet_start_seq.sv
`timescale 1ns/1ps
module quiet_start_seq #(
   parameter int DW           = 9,
   parameter int FW           = 24,
   parameter int SOFT_TICKS   = 1230,
   parameter int ACCEL_TICKS  = 1600,
   parameter int HOLD_TICKS   = 500,
   parameter int SLOW_HALF    = 30,
   parameter int FAST_HALF    = 15,
   parameter int START_FREQ   = 8120,
   parameter int FMAX_STD     = 5000000,
   parameter int FMAX_EXT     = 10000000,
   parameter int LVL_STD_HI   = 256,
   parameter int LVL_STD_LO   = 128,
   parameter int LVL_EXT_HI   = 85,
   parameter int LVL_EXT_LO   = 43,
   parameter int HANDOVER_PCT = 51
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_1ms,
   input  logic          start_req,
   input  logic [3:0]    param_code,
   input  logic          drive_sel,
   input  logic [DW-1:0] target_dmd,
   output logic [DW-1:0] demand,
   output logic [FW-1:0] freq_cmd,
   output logic          closed_loop
);
   import qs_pkg::*;

   localparam int MAXT_A = (SOFT_TICKS > ACCEL_TICKS) ? SOFT_TICKS : ACCEL_TICKS;
   localparam int MAXT   = (MAXT_A > HOLD_TICKS) ? MAXT_A : HOLD_TICKS;
   localparam int CW     = $clog2(MAXT + 1);

   // elaboration-time parameter checks
   generate
      if (DW < 3 || FW < 2)
         begin : g_bad_width  $error("quiet_start_seq: DW or FW too small"); end
      if (SOFT_TICKS < 1 || ACCEL_TICKS < 1 || HOLD_TICKS < 1)
         begin : g_bad_window $error("quiet_start_seq: windows must be at least one tick"); end
      if (FAST_HALF < 2 || SLOW_HALF < FAST_HALF)
         begin : g_bad_pace   $error("quiet_start_seq: pacing thresholds out of order"); end
      if (LVL_STD_HI >= 2**DW || LVL_STD_LO >= 2**DW || LVL_EXT_HI >= 2**DW || LVL_EXT_LO >= 2**DW)
         begin : g_bad_level  $error("quiet_start_seq: level does not fit DW"); end
      if (HANDOVER_PCT > 100)
         begin : g_bad_pct    $error("quiet_start_seq: handover percentage above 100"); end
      if (START_FREQ > FMAX_STD || START_FREQ > FMAX_EXT || FMAX_STD >= 2**FW || FMAX_EXT >= 2**FW)
         begin : g_bad_freq   $error("quiet_start_seq: frequency limits inconsistent"); end
   endgenerate

   qs_state_e               st;
   logic [CW-1:0]           cnt;
   logic [CW-1:0]           cnt_nx;
   logic                    cfg_ok;
   logic [DW-1:0]           lvl;
   logic [DW-1:0]           ho_lvl;
   logic [INC_W-1:0]        inc;
   logic [FW-1:0]           fmax;
   logic [DW-1:0]           amp;
   logic [FW-1:0]           freq_nx;
   logic                    step_up;
   logic                    step_dn;

   assign cnt_nx = cnt + CW'(1);

   su_cfg_latch #(
      .DW(DW), .FW(FW),
      .LVL_STD_HI(LVL_STD_HI), .LVL_STD_LO(LVL_STD_LO),
      .LVL_EXT_HI(LVL_EXT_HI), .LVL_EXT_LO(LVL_EXT_LO),
      .HANDOVER_PCT(HANDOVER_PCT), .FMAX_STD(FMAX_STD), .FMAX_EXT(FMAX_EXT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .code_in(param_code), .sel_in(drive_sel),
      .cfg_ok(cfg_ok), .lvl(lvl), .ho_lvl(ho_lvl), .inc(inc), .fmax(fmax)
   );

   su_soft_shape #(.DW(DW), .CW(CW), .SOFT_TICKS(SOFT_TICKS)) u_shape (
      .lvl(lvl), .k(cnt_nx), .amp(amp)
   );

   su_freq_step #(.FW(FW)) u_fstep (
      .freq(freq_cmd), .inc(inc), .fmax(fmax), .freq_nx(freq_nx)
   );

   su_dmd_pacer #(.DW(DW), .SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_pace (
      .clk(clk), .rst_n(rst_n), .run(st == ST_TRACK), .tick(tick_1ms),
      .cur(demand), .target(target_dmd), .step_up(step_up), .step_dn(step_dn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !start_req) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         demand   <= '0;
         freq_cmd <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cfg_ok) begin
                  st       <= ST_SOFT;
                  cnt      <= '0;
                  demand   <= '0;
                  freq_cmd <= FW'(START_FREQ);
               end
            end
            ST_SOFT: begin
               if (tick_1ms) begin
                  demand <= amp;
                  if (cnt_nx == CW'(SOFT_TICKS)) begin
                     st  <= ST_ACCEL;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt_nx;
                  end
               end
            end
            ST_ACCEL: begin
               if (tick_1ms) begin
                  freq_cmd <= freq_nx;
                  if (cnt_nx == CW'(ACCEL_TICKS)) begin
                     st     <= ST_HOLD;
                     cnt    <= '0;
                     demand <= ho_lvl;
                  end else begin
                     cnt <= cnt_nx;
                  end
               end
            end
            ST_HOLD: begin
               if (tick_1ms) begin
                  if (cnt_nx == CW'(HOLD_TICKS)) begin
                     st  <= ST_TRACK;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt_nx;
                  end
               end
            end
            ST_TRACK: begin
               if (step_up)      demand <= demand + DW'(1);
               else if (step_dn) demand <= demand - DW'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign closed_loop = (st == ST_HOLD) || (st == ST_TRACK);
endmodule

// File: rtl/qs_checker.sv
`timescale 1ns/1ps
module qs_checker #(
   parameter int DW       = 9,
   parameter int FW       = 24,
   parameter int FMAX_STD = 5000000,
   parameter int FMAX_EXT = 10000000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_1ms,
   input logic          start_req,
   input logic [DW-1:0] demand,
   input logic [FW-1:0] freq_cmd,
   input logic          closed_loop
);
   localparam int FTOP = (FMAX_STD > FMAX_EXT) ? FMAX_STD : FMAX_EXT;

   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_req |=> (demand == '0 && freq_cmd == '0 && !closed_loop));

   p_mode_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(closed_loop) |-> !$past(start_req));

   p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !tick_1ms) |=> $stable(demand));

   p_freq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && $past(start_req)) |-> (freq_cmd >= $past(freq_cmd)));

   p_freq_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      freq_cmd <= FW'(FTOP));

   p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (closed_loop && $past(closed_loop)) |->
         ({1'b0, demand} == {1'b0, $past(demand)} ||
          {1'b0, demand} == {1'b0, $past(demand)} + (DW+1)'(1) ||
          {1'b0, demand} + (DW+1)'(1) == {1'b0, $past(demand)}));
endmodule

bind quiet_start_seq qs_checker #(
   .DW(DW), .FW(FW), .FMAX_STD(FMAX_STD), .FMAX_EXT(FMAX_EXT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .start_req(start_req),
   .demand(demand), .freq_cmd(freq_cmd), .closed_loop(closed_loop)
);

// File: tb/quiet_start_seq_tb.sv
`timescale 1ns/1ps
module quiet_start_seq_tb;
   localparam int DW = 9, FW = 24;
   localparam int SOFT = 10, ACCEL = 8, HOLD = 4;
   localparam int START = 8120, FMS = 10000, FMX = 20000;
   localparam int LSH = 256, LSL = 128, LXH = 85, LXL = 43;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, sel = 1'b0;
   logic [3:0]    code = '0;
   logic [DW-1:0] target = '0;
   logic [DW-1:0] demand;
   logic [FW-1:0] freq;
   logic          mode;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   quiet_start_seq #(
      .DW(DW), .FW(FW), .SOFT_TICKS(SOFT), .ACCEL_TICKS(ACCEL), .HOLD_TICKS(HOLD),
      .START_FREQ(START), .FMAX_STD(FMS), .FMAX_EXT(FMX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .start_req(start),
      .param_code(code), .drive_sel(sel), .target_dmd(target),
      .demand(demand), .freq_cmd(freq), .closed_loop(mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lvl_of(input int c, input int s);
      if (c >= 8) return s ? LXH : LXL;
      return s ? LSH : LSL;
   endfunction

   function automatic int inc_of(input int c);
      case (c)
         0: return 31;  1: return 51;  2: return 70;  3: return 90;
         4: return 109; 5: return 148; 6: return 188;
         default: return 266;
      endcase
   endfunction

   function automatic int fmax_of(input int c);
      return (c >= 8) ? FMX : FMS;
   endfunction

   task automatic one_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic do_reset(input int c, input int s);
      start = 1'b0; tick = 1'b0; rst_n = 1'b0;
      code = 4'(c); sel = s[0];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // scramble the configuration inputs after capture (R2)
      code = ~4'(c); sel = ~s[0];
      @(negedge clk);
   endtask

   task automatic check_idle(input string req);
      chk(demand == '0, req, int'(demand), 0);
      chk(freq == '0, req, int'(freq), 0);
      chk(mode == 1'b0, req, int'(mode), 0);
   endtask

   task automatic run_cfg(input int c, input int s, input int tgt, input int nramp);
      int lv, ho, fexp, d, cr, thr;
      lv = lvl_of(c, s);
      ho = (lv * 51) / 100;
      do_reset(c, s);
      check_idle("R1 reset");
      target = DW'(tgt);
      start = 1'b1;
      @(negedge clk);
      chk(freq == FW'(START), "R4 start freq", int'(freq), START);
      chk(demand == '0, "R4 start demand", int'(demand), 0);
      for (int k = 1; k <= SOFT; k++) begin
         one_tick();
         chk(demand == DW'((lv * k) / SOFT), "R4 soft ramp", int'(demand), (lv * k) / SOFT);
         chk(freq == FW'(START), "R4 soft freq", int'(freq), START);
         chk(mode == 1'b0, "R4 open loop", int'(mode), 0);
      end
      chk(demand == DW'(lv), "R2 captured config", int'(demand), lv);
      chk(demand == DW'(lv), "R3 level select", int'(demand), lv);
      fexp = START;
      for (int j = 1; j <= ACCEL; j++) begin
         one_tick();
         fexp = fexp + inc_of(c);
         if (fexp > fmax_of(c)) fexp = fmax_of(c);
         chk(freq == FW'(fexp), "R5 R6 freq ramp", int'(freq), fexp);
         if (j < ACCEL) begin
            chk(demand == DW'(lv), "R5 level held", int'(demand), lv);
            chk(mode == 1'b0, "R5 open loop", int'(mode), 0);
         end else begin
            chk(demand == DW'(ho), "R7 handover level", int'(demand), ho);
            chk(mode == 1'b1, "R7 handover mode", int'(mode), 1);
         end
      end
      for (int h = 1; h <= HOLD; h++) begin
         one_tick();
         chk(demand == DW'(ho), "R7 hold demand", int'(demand), ho);
         chk(freq == FW'(fexp), "R7 hold freq", int'(freq), fexp);
         chk(mode == 1'b1, "R7 hold mode", int'(mode), 1);
      end
      d = ho; cr = 0;
      for (int n = 1; n <= nramp; n++) begin
         one_tick();
         if (d != tgt) begin
            thr = (d < 128) ? 30 : 15;
            cr = cr + 2;
            if (cr >= thr) begin
               cr = cr - thr;
               d = (tgt > d) ? d + 1 : d - 1;
            end
         end else begin
            cr = 0;
         end
         chk(demand == DW'(d), "R8 ramp pace", int'(demand), d);
      end
      start = 1'b0;
      @(negedge clk);
      check_idle("R10 withdraw in ramp");
   endtask

   task automatic abort_run();
      int lv;
      lv = lvl_of(3, 1);
      do_reset(3, 1);
      start = 1'b1;
      @(negedge clk);
      for (int k = 1; k <= 4; k++) one_tick();
      chk(demand == DW'((lv * 4) / SOFT), "R4 partial soft", int'(demand), (lv * 4) / SOFT);
      repeat (20) @(negedge clk);
      chk(demand == DW'((lv * 4) / SOFT), "R11 no tick no change", int'(demand), (lv * 4) / SOFT);
      start = 1'b0;
      @(negedge clk);
      check_idle("R10 withdraw in soft");
      start = 1'b1;
      @(negedge clk);
      chk(freq == FW'(START), "R10 restart freq", int'(freq), START);
      chk(demand == '0, "R10 restart demand", int'(demand), 0);
      for (int k = 1; k <= SOFT + 3; k++) one_tick();
      chk(freq == FW'(START + 3 * inc_of(3)), "R5 mid accel", int'(freq), START + 3 * inc_of(3));
      start = 1'b0;
      @(negedge clk);
      check_idle("R10 withdraw in accel");
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lv, ho, t;
      for (int c = 0; c < 16; c++) begin
         for (int s = 0; s < 2; s++) begin
            lv = lvl_of(c, s);
            ho = (lv * 51) / 100;
            t  = ho + (s ? 25 : -9) + c;
            run_cfg(c, s, t, 160);
         end
      end
      // R9 upward across the quarter-scale pace change, then settled
      run_cfg(0, 0, 140, 1100);
      // R9 downward across the quarter-scale pace change, then settled
      run_cfg(0, 1, 100, 450);
      abort_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule